// File: doc/BRIEF.md
# Periodic Timeout and Low-Power Stop Controller

This block pairs a free-running timeout counter with the state machine that puts the chip into its stop state and brings it back out. The counter advances once per reference clock cycle. Its terminal pulse marks the end of each timeout period. The period is chosen by a small select field as a power of two, and the shortest setting is 2^BASE_LOG2 cycles (4096 by default). Each terminal pulse sets a sticky flag. The flag raises an interrupt request only while the interrupt enable is set, and software clears it by writing 1.

The CPU asks to stop by raising a request. The controller then drops the oscillator enable and the core clock enable, raises its internal stop state, and clears the counter so that every stop starts from the same counter phase. An interrupt input whose enable bit is set wakes the block. With the delay option clear, the core clock comes back on the next cycle. With the delay option set, the oscillator restarts at once, but the core clock stays gated while the counter counts one full shortest period from zero.

If a stop request arrives in the same cycle as a terminal pulse, both still take effect. The oscillator enable and the stop state both come from the same next-state decision, so the oscillator can never be off while the stop state is low.

Top module: `rti_stop_ctrl`

## Requirements
- R1: Outside the stop state the counter increments every cycle. With select value n, tick pulses for one cycle each time the low BASE_LOG2+n counter bits are all ones, which is once every 2^(BASE_LOG2+n) cycles. Select 0 gives the shortest period.
- R2: When por_n is low (asynchronous) or rst_n is low (synchronous), the counter and flag are cleared and the controller returns to running: osc_en=1, core_clk_en=1, stop_active=0.
- R3: A stop_req sampled while running makes osc_en=0, core_clk_en=0 and stop_active=1 from the next cycle on, and clears the counter to zero. The counter holds at zero while stopped.
- R4: A stop_req sampled in the same cycle as a tick still enters the stop state, and rti_flag is set.
- R5: osc_en is never low while stop_active is low.
- R6: While stopped, the block wakes only if some bit of irq_in is high with the matching irq_en bit set. Masked interrupt inputs leave it stopped.
- R7: On a wake with dly_en=0, core_clk_en and osc_en are high in the cycle after the wake edge.
- R8: On a wake with dly_en=1, osc_en is high and stop_active is low right after the wake edge. core_clk_en then stays low for exactly 2^BASE_LOG2 cycles while the counter counts up from zero.
- R9: A tick sets rti_flag. A flag_clr pulse clears it. If a tick and flag_clr arrive in the same cycle, the tick wins and the flag stays set.
- R10: rti_irq is high exactly when rti_flag and rti_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low |
| stop_req | input | 1 | Stop request from the CPU |
| irq_in | input | N_IRQ | Wake interrupt sources |
| irq_en | input | N_IRQ | Per-source wake enables |
| dly_en | input | 1 | Stabilization delay option for wake-up |
| rti_sel | input | SEL_W | Period select n, period 2^(BASE_LOG2+n) |
| rti_en | input | 1 | Timeout interrupt enable |
| flag_clr | input | 1 | Write-1 clear of the timeout flag |
| tick | output | 1 | One-cycle terminal pulse of the selected period |
| rti_flag | output | 1 | Sticky timeout flag |
| rti_irq | output | 1 | Timeout interrupt request |
| osc_en | output | 1 | Oscillator enable |
| stop_active | output | 1 | Internal stop state |
| core_clk_en | output | 1 | Core clock gate enable |

## Verification
The bench builds the block with BASE_LOG2=4, SEL_W=2 and N_IRQ=3. With these values every period from 16 to 128 cycles and the full wake delay of 16 cycles fall within a few thousand cycles of random traffic. This lets the bench hit many stop entries at arbitrary counter phases and drive several stop requests that coincide exactly with a terminal pulse. The three-source interrupt vector is small enough that random enables often leave every active source masked, so the masked-wake case comes up often.

// File: rtl/rti_pkg.sv
package rti_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_STOP  = 2'd1,
      ST_DELAY = 2'd2
   } rti_state_e;
endpackage

// File: rtl/rti_counter.sv
module rti_counter #(
   parameter int BASE_LOG2 = 12,
   parameter int SEL_W     = 3
) (
   input  logic                                     clk,
   input  logic                                     por_n,
   input  logic                                     rst_n,
   input  logic                                     clr,
   input  logic                                     run,
   input  logic [SEL_W-1:0]                         sel,
   output logic [BASE_LOG2+(1<<SEL_W)-2:0]          cnt,
   output logic                                     term,
   output logic                                     base_done
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = BASE_LOG2 + NSEL - 1;

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("rti_counter: BASE_LOG2 must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("rti_counter: SEL_W must lie in 1..4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [NSEL-1:0]  term_vec;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       cnt_q <= '0;
      else if (!rst_n)  cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (run)     cnt_q <= cnt_q + 1'b1;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSEL; gi++) begin : g_term
         assign term_vec[gi] = &cnt_q[BASE_LOG2+gi-1:0];
      end
   endgenerate

   assign cnt       = cnt_q;
   assign term      = run & term_vec[sel];
   assign base_done = term_vec[0];
endmodule

// File: rtl/rti_flag.sv
module rti_flag (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       flag_q <= 1'b0;
      else if (!rst_n)  flag_q <= 1'b0;
      else if (tick)    flag_q <= 1'b1;
      else if (clr)     flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & ie;

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      tick |=> flag);

   // R9
   flag_clr_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (clr && !tick) |=> !flag);
endmodule

// File: rtl/rti_stop_fsm.sv
module rti_stop_fsm
   import rti_pkg::*;
#(
   parameter int BASE_LOG2 = 12
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic stop_req,
   input  logic wake,
   input  logic dly_en,
   input  logic base_done,
   output logic cnt_clr,
   output logic cnt_run,
   output logic osc_en,
   output logic stop_active,
   output logic core_clk_en
);
   localparam int DLY_CYC = 1 << BASE_LOG2;
   localparam int DW      = BASE_LOG2 + 1;

   rti_state_e state_q, state_d;
   logic osc_q, stop_q, core_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:   if (stop_req) state_d = ST_STOP;
         ST_STOP:  if (wake)     state_d = dly_en ? ST_DELAY : ST_RUN;
         ST_DELAY: if (base_done) state_d = ST_RUN;
         default:  state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_RUN;
         osc_q   <= 1'b1;
         stop_q  <= 1'b0;
         core_q  <= 1'b1;
      end else if (!rst_n) begin
         state_q <= ST_RUN;
         osc_q   <= 1'b1;
         stop_q  <= 1'b0;
         core_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         osc_q   <= (state_d != ST_STOP);
         stop_q  <= (state_d == ST_STOP);
         core_q  <= (state_d == ST_RUN);
      end
   end

   assign cnt_clr     = (state_q == ST_STOP) | ((state_q == ST_RUN) & stop_req);
   assign cnt_run     = (state_q != ST_STOP);
   assign osc_en      = osc_q;
   assign stop_active = stop_q;
   assign core_clk_en = core_q;

   // delay window length monitor
   logic [DW-1:0] dly_len_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    dly_len_q <= '0;
      else if (!rst_n)               dly_len_q <= '0;
      else if (state_q == ST_DELAY)  dly_len_q <= dly_len_q + 1'b1;
      else                           dly_len_q <= '0;
   end

   // R5
   osc_off_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !osc_en |-> stop_active);

   // R6
   nowake_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (stop_active && !wake) |=> stop_active);

   // R7
   nodly_wake_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (stop_active && wake && !dly_en) |=> (core_clk_en && osc_en));

   // R8
   dly_len_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (state_q == ST_DELAY) |-> (dly_len_q < DW'(DLY_CYC) && osc_en && !core_clk_en));
endmodule

// File: rtl/rti_stop_ctrl.sv
module rti_stop_ctrl #(
   parameter int BASE_LOG2 = 12,
   parameter int SEL_W     = 3,
   parameter int N_IRQ     = 4
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             dly_en,
   input  logic [SEL_W-1:0] rti_sel,
   input  logic             rti_en,
   input  logic             flag_clr,
   output logic             tick,
   output logic             rti_flag,
   output logic             rti_irq,
   output logic             osc_en,
   output logic             stop_active,
   output logic             core_clk_en
);
   localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("rti_stop_ctrl: N_IRQ must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic cnt_clr, cnt_run, base_done, wake;

   assign wake = |(irq_in & irq_en);

   rti_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) i_cnt (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run),
      .sel(rti_sel), .cnt(cnt), .term(tick), .base_done(base_done)
   );

   rti_stop_fsm #(.BASE_LOG2(BASE_LOG2)) i_fsm (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
      .dly_en(dly_en), .base_done(base_done), .cnt_clr(cnt_clr), .cnt_run(cnt_run),
      .osc_en(osc_en), .stop_active(stop_active), .core_clk_en(core_clk_en)
   );

   rti_flag i_flag (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .clr(flag_clr),
      .ie(rti_en), .flag(rti_flag), .irq(rti_irq)
   );

   // R3
   stop_clr_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(stop_active) |-> (cnt == '0));

   // R4
   coincide_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (tick && stop_req && core_clk_en) |=> (stop_active && !osc_en && rti_flag));
endmodule

// File: tb/test_rti_stop_ctrl.sv
module test_rti_stop_ctrl;
   localparam int B  = 4;
   localparam int SW = 2;
   localparam int NI = 3;
   localparam int CW = B + (1 << SW) - 1;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b0;
   logic stop_req = 1'b0, dly_en = 1'b0, rti_en = 1'b0, flag_clr = 1'b0;
   logic [NI-1:0] irq_in = '0, irq_en = '0;
   logic [SW-1:0] rti_sel = '0;
   logic tick, rti_flag, rti_irq, osc_en, stop_active, core_clk_en;

   int vectors = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rti_stop_ctrl #(.BASE_LOG2(B), .SEL_W(SW), .N_IRQ(NI)) i_rti_stop_ctrl (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .stop_req(stop_req),
      .irq_in(irq_in), .irq_en(irq_en), .dly_en(dly_en), .rti_sel(rti_sel),
      .rti_en(rti_en), .flag_clr(flag_clr), .tick(tick), .rti_flag(rti_flag),
      .rti_irq(rti_irq), .osc_en(osc_en), .stop_active(stop_active),
      .core_clk_en(core_clk_en)
   );

   // reference model: 0 run, 1 stop, 2 delay
   logic [CW-1:0] m_cnt;
   int m_st;
   logic m_flag;

   function automatic logic m_tick();
      logic [CW-1:0] mask;
      mask = CW'((1 << (B + int'(rti_sel))) - 1);
      return (m_st != 1) && ((m_cnt & mask) == mask);
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n || !rst_n) begin
         m_cnt = '0; m_st = 0; m_flag = 1'b0;
      end else begin
         automatic logic t = m_tick();
         automatic logic w = |(irq_in & irq_en);
         if (t) m_flag = 1'b1;
         else if (flag_clr) m_flag = 1'b0;
         case (m_st)
            0: if (stop_req) begin m_st = 1; m_cnt = '0; end
               else m_cnt = m_cnt + 1'b1;
            1: begin m_cnt = '0; if (w) m_st = dly_en ? 2 : 0; end
            default: begin
               if (m_cnt == CW'((1 << B) - 1)) m_st = 0;
               m_cnt = m_cnt + 1'b1;
            end
         endcase
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk("R1 tick", tick, m_tick());
      chk("R9 flag", rti_flag, m_flag);
      chk("R10 irq", rti_irq, m_flag & rti_en);
      chk("R3 osc_en", osc_en, m_st != 1);
      chk("R3 stop_active", stop_active, m_st == 1);
      chk("R7 core_clk_en", core_clk_en, m_st == 0);
      chk("R5 osc vs stop", !osc_en && !stop_active, 1'b0);
   endtask

   task automatic idle_inputs();
      stop_req = 0; flag_clr = 0; irq_in = '0;
   endtask

   initial begin
      int n;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      por_n = 1; rst_n = 1;
      step();
      // R2: reset state
      chk("R2 reset flag", rti_flag, 1'b0);
      chk("R2 reset osc", osc_en, 1'b1);
      chk("R2 reset core", core_clk_en, 1'b1);

      // R1: shortest period from reset
      rti_sel = 0;
      repeat (40) step();

      // R4: stop request exactly on a tick
      for (int k = 0; k < 3; k++) begin
         while (!(m_tick() && m_st == 0)) step();
         stop_req = 1;
         step();
         stop_req = 0;
         chk("R4 stop entered", stop_active, 1'b1);
         chk("R4 osc off", osc_en, 1'b0);
         chk("R4 flag set", rti_flag, 1'b1);
         // R6: masked interrupts ignored
         irq_en = '0; irq_in = '1;
         repeat (5) step();
         chk("R6 masked stays stopped", stop_active, 1'b1);
         // R8: wake with delay
         dly_en = 1; irq_en = 3'b010; irq_in = 3'b010;
         step();
         irq_in = '0; irq_en = '0;
         chk("R8 osc restart", osc_en, 1'b1);
         chk("R8 stop left", stop_active, 1'b0);
         n = 0;
         while (!core_clk_en && n < 1000) begin n++; step(); end
         chk("R8 delay length", n == (1 << B), 1'b1);
         rti_sel = SW'(k);
         flag_clr = 1; step(); flag_clr = 0;
      end

      // R7: wake without delay
      stop_req = 1; step(); stop_req = 0;
      dly_en = 0; irq_en = 3'b001; irq_in = 3'b001; step();
      idle_inputs();
      chk("R7 immediate core", core_clk_en, 1'b1);

      // R2: synchronous reset mid-run
      repeat (7) step();
      rst_n = 0; step(); rst_n = 1;
      chk("R2 sync reset flag", rti_flag, 1'b0);
      chk("R2 sync reset core", core_clk_en, 1'b1);

      // random traffic
      for (int c = 0; c < 6000; c++) begin
         stop_req = (m_st == 0) && ($urandom_range(59) == 0);
         flag_clr = ($urandom_range(7) == 0);
         irq_in   = ($urandom_range(5) == 0) ? NI'($urandom) : '0;
         if ($urandom_range(49) == 0) begin
            irq_en = NI'($urandom); dly_en = $urandom_range(1);
            rti_en = $urandom_range(1); rti_sel = SW'($urandom);
         end
         step();
      end

      // R2: asynchronous power-on reset
      @(negedge clk); por_n = 0; #2;
      chk("R2 por flag", rti_flag, 1'b0);
      chk("R2 por stop", stop_active, 1'b0);
      #3 por_n = 1;
      idle_inputs();
      repeat (4) step();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule